// File: doc/BRIEF.md
# Parallel Flash Bus Interface

This block is the pin-level front end of an asynchronous byte-wide flash device with a 128K-entry address space. The host drives three active-low strobes (chip enable, output enable, write enable), a 17-bit address and a shared 8-bit data bus. The block samples all of these through synchronizers clocked by a fast internal clock. From them it works out the current bus mode. It drives read data back onto the shared bus only when the device is both selected and output-enabled. When a write cycle ends, it hands the command address and data to a downstream command state machine as a single-cycle strobe.

A write cycle is any interval in which chip enable and write enable are both low while output enable is high. The command address is the one on the pins at the moment that interval opens. That moment is the later of the two strobe falls. The command data is the value on the bus at the last sample before the interval closes. That moment is the earlier of the two strobe rises. A dedicated input replaces the high-voltage identifier request. While it is set, reads return identifier bytes instead of array data. Address bit 0 picks the byte and address bit 1 forces a zero byte.

Top module: `pflash_bus_if`

## Requirements
- R1: With chip enable and output enable both low in the pin sample taken at rising edge k, `dq_oe` is high after edge k+2 and `dq` carries the read byte for the address sampled at edge k. Outside identifier mode, that byte is `arr_rdata` for the address presented on `arr_addr`.
- R2: If either chip enable or output enable is high in the sample at edge k, `dq_oe` is low and the bus is released after edge k+2. With chip enable high this holds whatever output enable does.
- R3: A write cycle is a run of samples with chip enable low, write enable low and output enable high. It ends when chip enable or write enable rises. The first sample with the cycle closed is taken at edge j. `cmd_valid` is then high for exactly the one cycle after edge j+2.
- R4: `cmd_addr` during the `cmd_valid` pulse equals the address in the first sample of the write cycle, that is, after the later of the two strobe falls. This holds for both fall orders.
- R5: `cmd_data` during the `cmd_valid` pulse equals the bus value in the last sample of the write cycle, that is, before the earlier of the two strobe rises. A change on the bus after that rise has no effect.
- R6: Chip enable, write enable and output enable all low together is a read. No `cmd_valid` follows. A write cycle cut short by output enable falling also produces no `cmd_valid`.
- R7: In identifier mode, a read returns `MFR_ID` when address bit 0 is low and `DEV_ID` when it is high, provided address bit 1 is low. All other address bits are ignored.
- R8: In identifier mode with address bit 1 high, the read byte is 0x00.
- R9: `bus_mode` after edge k+2 encodes the sample at edge k as follows: 0 means standby (chip enable high), 1 means output disabled (selected, output enable and write enable high), 2 means read (selected, output enable low) and 3 means write (selected, output enable high, write enable low).
- R10: While `rst` is high, `dq_oe`, `cmd_valid` and `bus_mode` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 17 | Host address pins |
| id_mode | input | 1 | Identifier-read request (stands in for the high-voltage level) |
| dq | inout | 8 | Shared data bus |
| arr_rdata | input | 8 | Array read byte for `arr_addr` |
| arr_addr | output | 17 | Synchronized address to the array |
| dq_oe | output | 1 | High while the block drives `dq` |
| bus_mode | output | 2 | Decoded bus mode (R9 encoding) |
| cmd_valid | output | 1 | One-cycle command strobe at the end of a write |
| cmd_addr | output | 17 | Captured command address |
| cmd_data | output | 8 | Captured command data |

## Verification
Writes are tried with chip enable falling first and write enable rising first, and with the reverse order. They are also tried with both strobes moving together. In each order the address and the data change around the strobe edges, so a capture taken on the wrong edge shows up as a wrong address or a wrong byte. Reads sweep several addresses back to back, and standby is held with output enable low, which separates the chip-enable gating from the output-enable gating. The all-low case and a write aborted by output enable test whether the write decode gives read priority. Identifier reads vary the don't-care bits together with bit 0 and bit 1.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_OUTDIS  = 2'd1,
    MODE_READ    = 2'd2,
    MODE_WRITE   = 2'd3
  } bus_mode_e;

  // Output enable low wins over write enable: all three low is a read.
  function automatic bus_mode_e decode_mode(input logic ce_n, input logic oe_n,
                                            input logic we_n);
    bus_mode_e m;
    if (ce_n)       m = MODE_STANDBY;
    else if (!oe_n) m = MODE_READ;
    else if (!we_n) m = MODE_WRITE;
    else            m = MODE_OUTDIS;
    return m;
  endfunction

  function automatic logic is_write(input logic ce_n, input logic oe_n,
                                    input logic we_n);
    return !ce_n && !we_n && oe_n;
  endfunction

endpackage

// File: rtl/pfb_sync.sv
module pfb_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/pfb_cmd_capture.sv
module pfb_cmd_capture
  import pfb_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_s,
  input  logic          oe_s,
  input  logic          we_s,
  input  logic [AW-1:0] addr_s,
  input  logic [DW-1:0] dq_s,
  output logic          cmd_valid,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data
);

  logic          wr_now;
  logic          wr_prev;
  logic          wr_open;
  logic          wr_close;
  logic [AW-1:0] addr_lat;
  logic [DW-1:0] data_lat;

  assign wr_now  = is_write(ce_s, oe_s, we_s);
  // Window opens at the later strobe fall (both low for the first time).
  assign wr_open = wr_now && !wr_prev;
  // Window closes at the earlier strobe rise; an output-enable fall is an abort.
  assign wr_close = wr_prev && !wr_now && (ce_s || we_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_prev   <= 1'b0;
      addr_lat  <= '0;
      data_lat  <= '0;
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      wr_prev   <= wr_now;
      cmd_valid <= wr_close;
      if (wr_open) addr_lat <= addr_s;
      if (wr_now)  data_lat <= dq_s;
      if (wr_close) begin
        cmd_addr <= addr_lat;
        cmd_data <= data_lat;
      end
    end
  end

endmodule

// File: rtl/pfb_read_path.sv
module pfb_read_path
  import pfb_pkg::*;
#(
  parameter int            AW     = 17,
  parameter int            DW     = 8,
  parameter logic [DW-1:0] MFR_ID = 8'hC7,
  parameter logic [DW-1:0] DEV_ID = 8'h5A
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_s,
  input  logic          oe_s,
  input  logic          we_s,
  input  logic          id_s,
  input  logic [AW-1:0] addr_s,
  input  logic [DW-1:0] arr_rdata,
  output logic          dq_oe,
  output logic [DW-1:0] dq_out,
  output logic [1:0]    bus_mode
);

  bus_mode_e     mode_nxt;
  logic [DW-1:0] id_byte;
  logic [DW-1:0] rd_byte;

  always_comb begin
    mode_nxt = decode_mode(ce_s, oe_s, we_s);
    if (addr_s[1])      id_byte = '0;
    else if (addr_s[0]) id_byte = DEV_ID;
    else                id_byte = MFR_ID;
    rd_byte = id_s ? id_byte : arr_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_oe    <= 1'b0;
      dq_out   <= '0;
      bus_mode <= MODE_STANDBY;
    end else begin
      dq_oe    <= (mode_nxt == MODE_READ);
      dq_out   <= rd_byte;
      bus_mode <= mode_nxt;
    end
  end

endmodule

// File: rtl/pflash_bus_if.sv
module pflash_bus_if
  import pfb_pkg::*;
#(
  parameter int            AW      = 17,
  parameter int            DW      = 8,
  parameter int            SYNC_ST = 2,
  parameter logic [DW-1:0] MFR_ID  = 8'hC7,
  parameter logic [DW-1:0] DEV_ID  = 8'h5A
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic          id_mode,
  inout  wire  [DW-1:0] dq,
  input  logic [DW-1:0] arr_rdata,
  output logic [AW-1:0] arr_addr,
  output logic          dq_oe,
  output logic [1:0]    bus_mode,
  output logic          cmd_valid,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data
);

  localparam int CTL_W = 4;

  logic [CTL_W-1:0] ctl_s;
  logic             ce_s, oe_s, we_s, id_s;
  logic [AW-1:0]    addr_s;
  logic [DW-1:0]    dq_s;
  logic [DW-1:0]    dq_out;

  pfb_sync #(.W(CTL_W), .STAGES(SYNC_ST), .RST_VAL(4'b1110)) u_sync_ctl (
    .clk (clk), .rst (rst),
    .din ({ce_n, oe_n, we_n, id_mode}),
    .dout(ctl_s)
  );

  pfb_sync #(.W(AW), .STAGES(SYNC_ST), .RST_VAL('0)) u_sync_addr (
    .clk (clk), .rst (rst), .din (addr), .dout(addr_s)
  );

  pfb_sync #(.W(DW), .STAGES(SYNC_ST), .RST_VAL('0)) u_sync_dq (
    .clk (clk), .rst (rst), .din (dq), .dout(dq_s)
  );

  assign {ce_s, oe_s, we_s, id_s} = ctl_s;
  assign arr_addr = addr_s;

  pfb_cmd_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .ce_s     (ce_s),
    .oe_s     (oe_s),
    .we_s     (we_s),
    .addr_s   (addr_s),
    .dq_s     (dq_s),
    .cmd_valid(cmd_valid),
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data)
  );

  pfb_read_path #(.AW(AW), .DW(DW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .ce_s     (ce_s),
    .oe_s     (oe_s),
    .we_s     (we_s),
    .id_s     (id_s),
    .addr_s   (addr_s),
    .arr_rdata(arr_rdata),
    .dq_oe    (dq_oe),
    .dq_out   (dq_out),
    .bus_mode (bus_mode)
  );

  for (genvar b = 0; b < DW; b++) begin : g_dq_drv
    assign dq[b] = dq_oe ? dq_out[b] : 1'bz;
  end

endmodule

module pflash_bus_if_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ce_n,
  input logic          oe_n,
  input logic          id_mode,
  input logic          a1,
  input logic [DW-1:0] dq,
  input logic          dq_oe,
  input logic          cmd_valid,
  input logic [1:0]    bus_mode
);

  AST_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (!$past(ce_n, 3) && !$past(oe_n, 3))); // R1

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(ce_n, 3) |-> !dq_oe); // R2

  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid); // R3

  AST_CMD_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> ($past(bus_mode) == 2'd3 && bus_mode != 2'd3)); // R6

  AST_ID_A1_ZERO: assert property (@(posedge clk) disable iff (rst)
    (dq_oe && $past(id_mode, 3) && $past(a1, 3)) |-> (dq == '0)); // R8

endmodule

bind pflash_bus_if pflash_bus_if_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ce_n     (ce_n),
  .oe_n     (oe_n),
  .id_mode  (id_mode),
  .a1       (addr[1]),
  .dq       (dq),
  .dq_oe    (dq_oe),
  .cmd_valid(cmd_valid),
  .bus_mode (bus_mode)
);

// File: tb/pflash_bus_if_test.sv
`timescale 1ns/1ps
module pflash_bus_if_test;

  localparam logic [7:0] T_MFR = 8'hC7;
  localparam logic [7:0] T_DEV = 8'h5A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, id_mode = 1'b0;
  logic [16:0] addr = '0;
  logic        tb_drv = 1'b0;
  logic [7:0]  tb_dq = '0;
  wire  [7:0]  dq;
  logic [7:0]  arr_rdata;
  logic [16:0] arr_addr, cmd_addr;
  logic        dq_oe, cmd_valid;
  logic [1:0]  bus_mode;
  logic [7:0]  cmd_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  assign dq = tb_drv ? tb_dq : 8'bz;

  function automatic logic [7:0] mem_f(input logic [16:0] a);
    logic [7:0] p;
    p = a[7:0] * 8'd13;
    return p ^ a[15:8] ^ {7'd0, a[16]};
  endfunction

  assign arr_rdata = mem_f(arr_addr);

  pflash_bus_if #(.MFR_ID(T_MFR), .DEV_ID(T_DEV)) uut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .id_mode(id_mode), .dq(dq), .arr_rdata(arr_rdata),
    .arr_addr(arr_addr), .dq_oe(dq_oe), .bus_mode(bus_mode),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  // Reference model: pin history, index 0 = newest sample.
  logic        hc[4], ho[4], hw[4], hi[4];
  logic [16:0] ha[4];
  logic [7:0]  hd[4];
  logic [24:0] pend[$];
  logic [16:0] start_addr;
  logic        e_oe, e_valid;
  logic [1:0]  e_mode;
  logic [7:0]  e_byte, e_cd;
  logic [16:0] e_ca;
  string       e_tag;

  function automatic logic w_of(input logic c, input logic o, input logic w);
    return !c && !w && o;
  endfunction

  function automatic logic [1:0] mode_of(input logic c, input logic o, input logic w);
    if (c) return 2'd0;
    if (!o) return 2'd2;
    if (!w) return 2'd3;
    return 2'd1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        hc[i] = ce_n; ho[i] = oe_n; hw[i] = we_n; hi[i] = id_mode;
        ha[i] = addr; hd[i] = dq;
      end
      pend.delete();
      e_valid = 1'b0;
    end else begin
      for (int i = 3; i > 0; i--) begin
        hc[i] = hc[i-1]; ho[i] = ho[i-1]; hw[i] = hw[i-1];
        hi[i] = hi[i-1]; ha[i] = ha[i-1]; hd[i] = hd[i-1];
      end
      hc[0] = ce_n; ho[0] = oe_n; hw[0] = we_n; hi[0] = id_mode;
      ha[0] = addr; hd[0] = dq;
      if (w_of(hc[0], ho[0], hw[0]) && !w_of(hc[1], ho[1], hw[1]))
        start_addr = ha[0];
      if (w_of(hc[1], ho[1], hw[1]) && !w_of(hc[0], ho[0], hw[0]) && (hc[0] || hw[0]))
        pend.push_back({start_addr, hd[1]});
      e_valid = w_of(hc[3], ho[3], hw[3]) && !w_of(hc[2], ho[2], hw[2]) && (hc[2] || hw[2]);
      if (e_valid && pend.size() > 0) {e_ca, e_cd} = pend.pop_front();
    end
    e_oe   = !hc[2] && !ho[2];
    e_mode = mode_of(hc[2], ho[2], hw[2]);
    if (hi[2]) begin
      e_byte = ha[2][1] ? 8'h00 : (ha[2][0] ? T_DEV : T_MFR);
      e_tag  = ha[2][1] ? "R8" : "R7";
    end else begin
      e_byte = mem_f(ha[2]);
      e_tag  = "R1";
    end
  end

  task automatic chk(input logic ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(dq_oe == e_oe, e_oe ? "R1" : "R2", "dq_oe", dq_oe, e_oe);
      chk(bus_mode == e_mode, "R9", "bus_mode", bus_mode, e_mode);
      chk(cmd_valid == e_valid, e_valid ? "R3" : "R6", "cmd_valid", cmd_valid, e_valid);
      if (e_valid && cmd_valid) begin
        chk(cmd_addr == e_ca, "R4", "cmd_addr", cmd_addr, e_ca);
        chk(cmd_data == e_cd, "R5", "cmd_data", cmd_data, e_cd);
      end
      if (e_oe && dq_oe) chk(dq == e_byte, e_tag, "dq", dq, e_byte);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // order 0: ce falls first, we rises first; 1: we falls first, ce rises first;
  // 2: both strobes move together.
  task automatic wr(input logic [16:0] a_first, input logic [16:0] a_final,
                    input logic [7:0] d, input int order);
    case (order)
      0: begin
        addr = a_first; ce_n = 1'b0; idle(2);
        addr = a_final; we_n = 1'b0; tb_drv = 1'b1; tb_dq = d; idle(3);
        we_n = 1'b1; tb_dq = ~d; idle(2);
        addr = a_first ^ 17'h1; ce_n = 1'b1; idle(1);
      end
      1: begin
        addr = a_first; we_n = 1'b0; tb_drv = 1'b1; tb_dq = 8'h00; idle(2);
        addr = a_final; tb_dq = d; ce_n = 1'b0; idle(3);
        ce_n = 1'b1; tb_dq = ~d; idle(1);
        we_n = 1'b1; idle(1);
      end
      default: begin
        addr = a_final; tb_drv = 1'b1; tb_dq = d; ce_n = 1'b0; we_n = 1'b0; idle(3);
        ce_n = 1'b1; we_n = 1'b1; tb_dq = ~d; idle(1);
      end
    endcase
    tb_drv = 1'b0;
    idle(4);
  endtask

  initial begin
    idle(4);
    // R10: reset state
    chk(dq_oe == 1'b0, "R10", "dq_oe in reset", dq_oe, 0);
    chk(cmd_valid == 1'b0, "R10", "cmd_valid in reset", cmd_valid, 0);
    chk(bus_mode == 2'd0, "R10", "bus_mode in reset", bus_mode, 0);
    rst = 1'b0;
    idle(3);

    // R1: back-to-back array reads
    ce_n = 1'b0; oe_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      addr = 17'h1_0000 + 17'(i) * 17'h0123;
      idle(1);
    end
    idle(2);
    oe_n = 1'b1; idle(2);
    // R2: standby with output enable low
    ce_n = 1'b1; oe_n = 1'b0; idle(5);
    // R9: output disabled
    oe_n = 1'b1; ce_n = 1'b0; idle(4);
    ce_n = 1'b1; idle(4);

    // R3 R4 R5: writes in each strobe order
    wr(17'h0_0AAA, 17'h1_5555, 8'hA5, 0);
    wr(17'h0_1234, 17'h0_2AAA, 8'h3C, 1);
    wr(17'h1_0F0F, 17'h1_0F0F, 8'h96, 2);

    // R6: all three low is a read
    addr = 17'h0_0042; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; idle(4);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; idle(4);
    // R6: write aborted by output enable
    addr = 17'h0_0777; ce_n = 1'b0; we_n = 1'b0; tb_drv = 1'b1; tb_dq = 8'h77; idle(2);
    tb_drv = 1'b0; oe_n = 1'b0; idle(3);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; idle(4);

    // R7 R8: identifier reads with don't-care bits varied
    id_mode = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    addr = 17'h0_0000; idle(1);
    addr = 17'h0_0001; idle(1);
    addr = 17'h1_5A3C; idle(1);
    addr = 17'h0_FFFD; idle(1);
    addr = 17'h0_0002; idle(1);
    addr = 17'h1_FFFF; idle(3);
    oe_n = 1'b1; ce_n = 1'b1; id_mode = 1'b0; idle(4);

    for (int i = 0; i < 6; i++)
      wr(17'(i * 4099), 17'(17'h1_1111 + i * 773), 8'(8'h11 * (i + 1)), i % 3);

    idle(6);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule